// File: doc/BRIEF.md
# Delay-Line Gain Calibration Correlator

This block runs in the background next to a fractional divider whose residual phase error is cancelled by a digitally controlled delay line. Each enabled cycle it takes the one-bit decision of a bang-bang phase detector and the delay code currently applied to the line. It forms the sign-error LMS product of the two and adds it into a saturating 14-bit correlation register. The register settles where the detector decisions no longer correlate with the delay code, which happens when the delay line spans exactly one input period.

A second-order error-feedback delta-sigma modulator reduces the 14-bit register to a 5-bit gain code. That code is expanded to a 31-line thermometer word for the supply-setting DAC of the line's regulator. A second, dummy delay line gets the bitwise complement of the active delay code, so that the regulator sees a constant load. A programmable right shift sets the loop step size. An enable input freezes the loop.

Top module: `dly_gain_cal`

## Requirements
- R1: `dummy_code` is the bitwise complement of `dly_code` in the same cycle, whether or not the loop is enabled.
- R2: The loop computes a correlation term on each enabled clock edge. It first centres the delay code as c = `dly_code` - 512. The term is +c when `pd_late` is 1 and -c when it is 0. The term is then arithmetically shifted right by `step_shift`, which rounds toward minus infinity. The result is added to the correlation register.
- R3: The correlation register is 14-bit two's complement. It saturates at 8191 and at -8192 instead of wrapping.
- R4: The modulator proceeds in these steps:
  - It forms u = register + 8192 and clamps u to the range [512, 15360].
  - It forms v = u + 2*e1 - e2, where e1 and e2 are its last two residues.
  - It produces q = floor((v+256)/512), clamped to the range 0..31.
  - It stores the new residue v - 512*q as e1, and moves the old e1 to e2.
- R5: The modulator uses the register value from before the same edge's addition, so `gain_code` takes the value q one clock after the register update that produced it.
- R6: `dac_therm` bit i is 1 exactly when `gain_code` > i, for i in 0..30. The number of ones therefore equals `gain_code`.
- R7: While `cal_en` is 0, the register, the modulator residues, `gain_code` and `dac_therm` hold their values, whatever the other inputs do.
- R8: After reset, the register and residues are 0 and `gain_code` is 16 (16 thermometer ones). Reset is asserted asynchronously and released through two flops.
- R9: With the input clamp of R4, the modulator residue stays within [-256, 255], so the quantizer never reaches its clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Loop enable; low freezes the loop |
| pd_late | input | 1 | Phase detector decision, 1 maps to +1 |
| dly_code | input | 10 | Delay code applied to the active line |
| step_shift | input | 4 | Right shift applied to the correlation term |
| dummy_code | output | 10 | Complement code for the dummy line |
| gain_code | output | 5 | Truncated gain correction |
| dac_therm | output | 31 | Thermometer word for the DAC |

## Verification
A wrong step, sign or shift in the correlator, or a wrapped register, is invisible inside one cycle. It shows up as a drift of the `gain_code` sequence away from the modelled bit stream, usually within a few to a few tens of enabled cycles; saturation errors appear only once the register is driven to its rail and then back. A corrupted modulator residue changes `gain_code` on the very next enabled edge. The checks therefore compare every cycle's gain code, the thermometer shape and the complement code against a cycle-exact model, including long rail runs and frozen stretches.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int unsigned CODE_W  = 10;
  localparam int unsigned ACC_W   = 14;
  localparam int unsigned OUT_W   = 5;
  localparam int unsigned SHIFT_W = 4;
endpackage

// File: rtl/dgc_corr.sv
module dgc_corr #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned ACC_W   = 14,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      pd_late,
  input  logic [CODE_W-1:0]         code,
  input  logic [SHIFT_W-1:0]        shift,
  output logic signed [ACC_W-1:0]   acc
);
  localparam int unsigned TW = CODE_W + 1;
  localparam int unsigned SW = ACC_W + 1;
  localparam logic signed [TW-1:0] HALF = TW'(1 << (CODE_W - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (ACC_W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 << (ACC_W - 1));

  logic signed [TW-1:0]    centred, term, scaled;
  logic signed [SW-1:0]    sum;
  logic signed [ACC_W-1:0] acc_nxt;

  always_comb begin
    centred = $signed({1'b0, code}) - HALF;
    term    = pd_late ? centred : -centred;
    scaled  = term >>> shift;
    sum     = SW'(acc) + SW'(scaled);
    if (sum > MAXV)      acc_nxt = ACC_W'(MAXV);
    else if (sum < MINV) acc_nxt = ACC_W'(MINV);
    else                 acc_nxt = ACC_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_nxt;
  end

  // R7: frozen while disabled
  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));
  // R3: a positive step at the top rail leaves the register on the rail
  a_r3_top_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc == ACC_W'(MAXV) && scaled > 0) |=> acc == ACC_W'(MAXV));
  // R3: a negative step at the bottom rail leaves the register on the rail
  a_r3_bottom_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc == ACC_W'(MINV) && scaled < 0) |=> acc == ACC_W'(MINV));
endmodule

// File: rtl/dgc_dsm2.sv
module dgc_dsm2 #(
  parameter int unsigned ACC_W = 14,
  parameter int unsigned OUT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  din,
  output logic [OUT_W-1:0]         code
);
  localparam int unsigned DW    = ACC_W + 3;
  localparam int unsigned LSB_W = ACC_W - OUT_W;
  localparam logic signed [DW-1:0] OFFS = DW'(1 << (ACC_W - 1));
  localparam logic signed [DW-1:0] ULO  = DW'(1 << LSB_W);
  localparam logic signed [DW-1:0] UHI  = DW'(((1 << OUT_W) - 2) << LSB_W);
  localparam logic signed [DW-1:0] RND  = DW'(1 << (LSB_W - 1));
  localparam logic signed [DW-1:0] QMAX = DW'((1 << OUT_W) - 1);

  logic signed [DW-1:0] e1, e2, u, v, qx, qs, e_nxt;
  logic [OUT_W-1:0]     code_nxt;

  always_comb begin
    u = DW'(din) + OFFS;
    if (u < ULO)      u = ULO;
    else if (u > UHI) u = UHI;
    v  = u + (e1 <<< 1) - e2;
    qx = (v + RND) >>> LSB_W;
    if (qx < 0)         qs = '0;
    else if (qx > QMAX) qs = QMAX;
    else                qs = qx;
    e_nxt    = v - (qs <<< LSB_W);
    code_nxt = qs[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1   <= '0;
      e2   <= '0;
      code <= OUT_W'(1 << (OUT_W - 1));
    end else if (en) begin
      e1   <= e_nxt;
      e2   <= e1;
      code <= code_nxt;
    end
  end

  // R9: residue bounded, quantizer never overloads
  a_r9_residue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (e1 >= -RND) && (e1 < RND));
  // R7: code and residues hold while disabled
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(code) && $stable(e1) && $stable(e2)));
  // R4: with the register clamped low the code cannot reach the top level
  a_r4_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din == -ACC_W'(1 << (ACC_W - 1))) |=> code != '1);
endmodule

// File: rtl/dgc_therm.sv
module dgc_therm #(
  parameter int unsigned OUT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [OUT_W-1:0]            bin,
  output logic [(1 << OUT_W) - 2:0]   therm
);
  localparam int unsigned LINES = (1 << OUT_W) - 1;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign therm[i] = (bin > OUT_W'(i));
  end

  // R6: number of ones equals the binary code
  a_r6_ones_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm) == bin);
  // R6: ones are contiguous from bit 0
  a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm + 1'b1) & therm) == '0);
endmodule

// File: rtl/dly_gain_cal.sv
module dly_gain_cal
  import dgc_pkg::*;
#(
  parameter int unsigned P_CODE_W  = CODE_W,
  parameter int unsigned P_ACC_W   = ACC_W,
  parameter int unsigned P_OUT_W   = OUT_W,
  parameter int unsigned P_SHIFT_W = SHIFT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cal_en,
  input  logic                          pd_late,
  input  logic [P_CODE_W-1:0]           dly_code,
  input  logic [P_SHIFT_W-1:0]          step_shift,
  output logic [P_CODE_W-1:0]           dummy_code,
  output logic [P_OUT_W-1:0]            gain_code,
  output logic [(1 << P_OUT_W) - 2:0]   dac_therm
);
  logic [1:0]                rst_sync;
  logic                      rst_int_n;
  logic signed [P_ACC_W-1:0] corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign dummy_code = ~dly_code;

  dgc_corr #(.CODE_W(P_CODE_W), .ACC_W(P_ACC_W), .SHIFT_W(P_SHIFT_W)) u_corr (
    .clk(clk), .rst_n(rst_int_n), .en(cal_en), .pd_late(pd_late),
    .code(dly_code), .shift(step_shift), .acc(corr)
  );

  dgc_dsm2 #(.ACC_W(P_ACC_W), .OUT_W(P_OUT_W)) u_dsm (
    .clk(clk), .rst_n(rst_int_n), .en(cal_en), .din(corr), .code(gain_code)
  );

  dgc_therm #(.OUT_W(P_OUT_W)) u_therm (
    .clk(clk), .rst_n(rst_int_n), .bin(gain_code), .therm(dac_therm)
  );

  // R8: out of reset the gain code sits at mid-scale
  a_r8_reset_mid: assert property (@(posedge clk)
    $rose(rst_int_n) |-> gain_code == P_OUT_W'(1 << (P_OUT_W - 1)));
endmodule

// File: tb/sim_dly_gain_cal.sv
module sim_dly_gain_cal;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_en = 1'b0;
  logic        pd_late = 1'b0;
  logic [9:0]  dly_code = '0;
  logic [3:0]  step_shift = '0;
  logic [9:0]  dummy_code;
  logic [4:0]  gain_code;
  logic [30:0] dac_therm;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    int    gc;
    logic [9:0] dum;
    string tag;
  } exp_t;
  exp_t q[$];

  int m_acc = 0, m_e1 = 0, m_e2 = 0, m_q = 16;

  always #10 clk = ~clk;

  dly_gain_cal u0 (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .pd_late(pd_late),
    .dly_code(dly_code), .step_shift(step_shift),
    .dummy_code(dummy_code), .gain_code(gain_code), .dac_therm(dac_therm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of R2..R5 and R7, one edge
  task automatic model_step(input bit pd, input int code, input int sh, input bit en);
    int u, v, qq, e, t;
    if (!en) return;
    u = m_acc + 8192;
    if (u < 512) u = 512;
    if (u > 15360) u = 15360;
    v = u + 2 * m_e1 - m_e2;
    qq = (v + 256) >>> 9;
    if (qq < 0) qq = 0;
    if (qq > 31) qq = 31;
    e = v - qq * 512;
    m_e2 = m_e1; m_e1 = e; m_q = qq;
    t = code - 512;
    if (!pd) t = -t;
    t = t >>> sh;
    m_acc = m_acc + t;
    if (m_acc > 8191) m_acc = 8191;
    if (m_acc < -8192) m_acc = -8192;
  endtask

  // driver: apply at falling edge, push expectation for the next rising edge
  task automatic drive(input bit pd, input int code, input int sh, input bit en, input string tag);
    exp_t it;
    @(negedge clk);
    pd_late = pd; dly_code = code[9:0]; step_shift = sh[3:0]; cal_en = en;
    model_step(pd, code, sh, en);
    it.gc = m_q; it.dum = ~code[9:0]; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: after each rising edge compare against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        logic [30:0] tx;
        it = q.pop_front();
        check(gain_code == it.gc[4:0], it.tag, gain_code, it.gc);
        for (int i = 0; i < 31; i++) tx[i] = (gain_code > i);
        check(dac_therm == tx, "R6 therm", dac_therm, tx);
        check(dummy_code == it.dum, "R1 dummy", dummy_code, it.dum);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check(gain_code == 5'd16, "R8 reset code", gain_code, 16);
    check($countones(dac_therm) == 16, "R8 reset therm", $countones(dac_therm), 16);
    // R2/R4/R5: alternating detector, mid step
    for (int i = 0; i < 40; i++) drive(i[0], 700, 2, 1'b1, "R2 alternating");
    // R4: steady positive correlation, small steps
    for (int i = 0; i < 60; i++) drive(1'b1, 600, 1, 1'b1, "R4 ramp up");
    // R3: drive into the top rail then back out
    for (int i = 0; i < 40; i++) drive(1'b1, 1023, 0, 1'b1, "R3 top rail");
    for (int i = 0; i < 30; i++) drive(1'b0, 1023, 3, 1'b1, "R3 leave top");
    // R7: disabled with changing inputs
    for (int i = 0; i < 20; i++) drive(i[1], i * 37, i % 16, 1'b0, "R7 frozen");
    // R3: bottom rail (code 0 with detector 0 gives +512... detector 1 gives -512)
    for (int i = 0; i < 40; i++) drive(1'b1, 0, 0, 1'b1, "R3 bottom rail");
    for (int i = 0; i < 30; i++) drive(1'b1, 1000, 2, 1'b1, "R3 leave bottom");
    // R2: maximal shift, negative terms round toward minus infinity
    for (int i = 0; i < 30; i++) drive(1'b0, 900, 15, 1'b1, "R2 max shift");
    // R5/R7: interleaved enable
    for (int i = 0; i < 40; i++) drive(1'b1, 300 + i, 2, i[0], "R5 gated");
    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], int'(lfsr[10:1]), int'(lfsr[14:12]), lfsr[15] | lfsr[5], "R4 random");
    end
    @(negedge clk);
    cal_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule